// File: doc/BRIEF.md
# Fence Interrupt Status Unit

This block follows fence completion and forward progress for a command-processing engine and turns them into one level interrupt. A command decoder reports each executed fence with a one-cycle strobe and the fence's 32-bit value, and it reports each step of forward progress with a one-cycle pulse. The unit keeps the value of the most recent fence. It compares every fence value against a goal that the host programs. It collects three event kinds in a sticky status register, and it drives the interrupt whenever an enabled status bit is set.

The host reaches the unit through a plain word-wide register port: write strobe, address, write data and a combinational read data bus. A driver programs the mask and the goal, then takes interrupts. It reads the status register to find the cause, and it writes ones back to the status register to acknowledge. The unit is only instantiated in configurations that report interrupt-mask support, which is capability bit 18 (value 0x00040000) of the device's capability word.

Top module: `fence_irq_unit`

## Requirements
- R1: After a synchronous active-high reset, the mask, status, goal and last-fence registers read zero, and `irq` is low.
- R2: The register map is as follows. Address 0x0 holds the mask (read/write, bits 2:0). Address 0x1 holds the goal (read/write, 32 bits). Address 0x2 holds the last fence (read-only). Address 0x8 holds the status (write-one-to-clear, bits 2:0). Unused bits and unmapped addresses read zero. In both mask and status, bit 0 means a fence executed, bit 1 means forward progress, and bit 2 means the goal was reached.
- R3: A fence strobe copies `fence_value` into the last-fence register, and the new value is readable in the next cycle.
- R4: Status bit 0 sets on every fence strobe, whatever the goal comparison gives and whatever the mask holds.
- R5: A `progress_pulse` sets status bit 1, whatever the mask holds.
- R6: A fence whose value equals the goal sets status bit 2 when mask bit 2 is set. The comparison uses the goal held before any goal write in the same cycle.
- R7: A fence matching the goal while mask bit 2 is clear leaves status bit 2 unchanged.
- R8: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: When a set event and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R10: `irq` is a register. In each cycle it equals the OR over all bits of (status AND mask) as they stood one cycle earlier.
- R11: Writes to the last-fence address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fence_valid | input | 1 | One-cycle strobe: a fence executed |
| fence_value | input | 32 | Value carried by the executed fence |
| progress_pulse | input | 1 | One-cycle strobe: forward progress made |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr`, combinational |
| irq | output | 1 | Level interrupt, registered |

## Verification
The bench aims at the collision cases. In one, a clearing write and a new event hit the same status bit in the same cycle; a design where the clear wins would lose an interrupt. In another, the goal is rewritten in the same cycle as a matching fence; a design comparing against the new goal would set or miss the goal flag wrongly. It also runs goal matches with the goal mask bit off, which must not set the flag. It masks and unmasks pending status to show that the interrupt follows one cycle late and never drops early. It writes to the read-only last-fence address, which a careless decoder would let overwrite the register.

// File: rtl/fence_irq_pkg.sv
package fence_irq_pkg;

    localparam int FLAG_W    = 3;
    localparam int FLAG_ANY  = 0;
    localparam int FLAG_PROG = 1;
    localparam int FLAG_GOAL = 2;

    localparam int RA_MASK   = 'h0;
    localparam int RA_GOAL   = 'h1;
    localparam int RA_LAST   = 'h2;
    localparam int RA_STATUS = 'h8;

    typedef logic [FLAG_W-1:0] flag_vec_t;

    typedef struct packed {
        logic mask_we;
        logic goal_we;
        logic status_we;
    } host_wr_t;

    function automatic host_wr_t decode_write(logic wr, int unsigned addr);
        host_wr_t d;
        d.mask_we   = wr && (addr == RA_MASK);
        d.goal_we   = wr && (addr == RA_GOAL);
        d.status_we = wr && (addr == RA_STATUS);
        return d;
    endfunction

endpackage

// File: rtl/fence_tracker.sv
module fence_tracker #(
    parameter int FENCE_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fence_valid,
    input  logic [FENCE_W-1:0] fence_value,
    input  logic               goal_we,
    input  logic [FENCE_W-1:0] goal_wdata,
    output logic [FENCE_W-1:0] last_q,
    output logic [FENCE_W-1:0] goal_q,
    output logic               goal_match
);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
            goal_q <= '0;
        end else begin
            if (fence_valid) last_q <= fence_value;
            if (goal_we)     goal_q <= goal_wdata;
        end
    end

    // match uses the goal as held before this cycle's write
    assign goal_match = fence_valid && (fence_value == goal_q);

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import fence_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t set_vec,
    input  flag_vec_t clr_vec,
    input  logic      mask_we,
    input  flag_vec_t mask_wdata,
    output flag_vec_t status_q,
    output flag_vec_t mask_q
);

    for (genvar b = 0; b < FLAG_W; b++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)               status_q[b] <= 1'b0;
            else if (set_vec[b])   status_q[b] <= 1'b1;
            else if (clr_vec[b])   status_q[b] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

endmodule

// File: rtl/irq_drive.sv
module irq_drive
    import fence_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t status_q,
    input  flag_vec_t mask_q,
    output logic      irq
);

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(status_q & mask_q);
    end

endmodule

// File: rtl/fence_irq_unit.sv
module fence_irq_unit
    import fence_irq_pkg::*;
#(
    parameter int FENCE_W = 32,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fence_valid,
    input  logic [FENCE_W-1:0] fence_value,
    input  logic               progress_pulse,
    input  logic               host_wr,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [FENCE_W-1:0] host_wdata,
    output logic [FENCE_W-1:0] host_rdata,
    output logic               irq
);

    localparam int PAD_W = FENCE_W - FLAG_W;

    host_wr_t           wdec;
    logic [FENCE_W-1:0] last_q;
    logic [FENCE_W-1:0] goal_q;
    logic               goal_match;
    flag_vec_t          status_q;
    flag_vec_t          mask_q;
    flag_vec_t          set_vec;
    flag_vec_t          clr_vec;

    assign wdec = decode_write(host_wr, int'(host_addr));

    fence_tracker #(.FENCE_W(FENCE_W)) trk_i (
        .clk        (clk),
        .rst        (rst),
        .fence_valid(fence_valid),
        .fence_value(fence_value),
        .goal_we    (wdec.goal_we),
        .goal_wdata (host_wdata),
        .last_q     (last_q),
        .goal_q     (goal_q),
        .goal_match (goal_match)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[FLAG_ANY]  = fence_valid;
        set_vec[FLAG_PROG] = progress_pulse;
        set_vec[FLAG_GOAL] = goal_match && mask_q[FLAG_GOAL];
        clr_vec            = wdec.status_we ? host_wdata[FLAG_W-1:0] : '0;
    end

    irq_flag_bank flg_i (
        .clk       (clk),
        .rst       (rst),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .mask_we   (wdec.mask_we),
        .mask_wdata(host_wdata[FLAG_W-1:0]),
        .status_q  (status_q),
        .mask_q    (mask_q)
    );

    irq_drive drv_i (
        .clk     (clk),
        .rst     (rst),
        .status_q(status_q),
        .mask_q  (mask_q),
        .irq     (irq)
    );

    always_comb begin
        if (host_addr == ADDR_W'(RA_MASK))
            host_rdata = {{PAD_W{1'b0}}, mask_q};
        else if (host_addr == ADDR_W'(RA_GOAL))
            host_rdata = goal_q;
        else if (host_addr == ADDR_W'(RA_LAST))
            host_rdata = last_q;
        else if (host_addr == ADDR_W'(RA_STATUS))
            host_rdata = {{PAD_W{1'b0}}, status_q};
        else
            host_rdata = '0;
    end

endmodule

// File: rtl/fence_irq_chk.sv
module fence_irq_chk
    import fence_irq_pkg::*;
#(
    parameter int FENCE_W = 32,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               fence_valid,
    input logic [FENCE_W-1:0] fence_value,
    input logic               progress_pulse,
    input logic               host_wr,
    input logic [ADDR_W-1:0]  host_addr,
    input logic [FENCE_W-1:0] host_wdata,
    input logic               irq,
    input flag_vec_t          status_q,
    input flag_vec_t          mask_q,
    input logic [FENCE_W-1:0] last_q,
    input logic [FENCE_W-1:0] goal_q
);

    logic clr_write;
    assign clr_write = host_wr && (host_addr == ADDR_W'(RA_STATUS));

    assert_last_capture_R3: assert property (@(posedge clk) disable iff (rst)
        fence_valid |=> last_q == $past(fence_value));

    assert_any_fence_R4: assert property (@(posedge clk) disable iff (rst)
        fence_valid |=> status_q[FLAG_ANY]);

    assert_progress_R5: assert property (@(posedge clk) disable iff (rst)
        progress_pulse |=> status_q[FLAG_PROG]);

    assert_goal_hit_R6: assert property (@(posedge clk) disable iff (rst)
        (fence_valid && fence_value == goal_q && mask_q[FLAG_GOAL]) |=> status_q[FLAG_GOAL]);

    assert_goal_masked_R7: assert property (@(posedge clk) disable iff (rst)
        (!status_q[FLAG_GOAL] && !mask_q[FLAG_GOAL]) |=> !status_q[FLAG_GOAL]);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (status_q[FLAG_ANY] && !clr_write) |=> status_q[FLAG_ANY]);

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        ((status_q & mask_q) == '0) |=> !irq);

    assert_last_readonly_R11: assert property (@(posedge clk) disable iff (rst)
        !fence_valid |=> $stable(last_q));

    logic unused_ok;
    assign unused_ok = ^{host_wdata, progress_pulse};

endmodule

bind fence_irq_unit fence_irq_chk #(.FENCE_W(FENCE_W), .ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .fence_valid   (fence_valid),
    .fence_value   (fence_value),
    .progress_pulse(progress_pulse),
    .host_wr       (host_wr),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .irq           (irq),
    .status_q      (status_q),
    .mask_q        (mask_q),
    .last_q        (last_q),
    .goal_q        (goal_q)
);

// File: tb/fence_irq_unit_tb_top.sv
`timescale 1ns/1ps
module fence_irq_unit_tb_top;

    localparam int FW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          fence_valid;
    logic [FW-1:0] fence_value;
    logic          progress_pulse;
    logic          host_wr;
    logic [AW-1:0] host_addr;
    logic [FW-1:0] host_wdata;
    logic [FW-1:0] host_rdata;
    logic          irq;

    always #2.5 clk = ~clk;

    fence_irq_unit #(.FENCE_W(FW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .fence_valid(fence_valid), .fence_value(fence_value),
        .progress_pulse(progress_pulse), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // behavioural reference state
    logic [2:0]  m_mask, m_status;
    logic [31:0] m_goal, m_last;
    logic        m_irq;
    string       prev_tag = "R1";

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(logic [3:0] a);
        case (a)
            4'h0:    return {29'b0, m_mask};
            4'h1:    return m_goal;
            4'h2:    return m_last;
            4'h8:    return {29'b0, m_status};
            default: return 32'h0;
        endcase
    endfunction

    // compare the result of the previous stimulus, then apply a new one
    task automatic cyc(string tag, logic fv, logic [31:0] fval, logic pg,
                       logic wr, logic [3:0] a, logic [31:0] wd);
        logic [2:0]  n_status, n_mask, setv, clrv;
        logic [31:0] n_goal, n_last;
        logic        n_irq;
        @(negedge clk);
        chk(prev_tag, host_rdata, exp_rd(host_addr));
        chk("R10", {31'b0, irq}, {31'b0, m_irq});
        fence_valid = fv; fence_value = fval; progress_pulse = pg;
        host_wr = wr; host_addr = a; host_wdata = wd;
        setv     = {fv && (fval == m_goal) && m_mask[2], pg, fv};
        clrv     = (wr && a == 4'h8) ? wd[2:0] : 3'b0;
        n_status = (m_status & ~clrv) | setv;
        n_mask   = (wr && a == 4'h0) ? wd[2:0] : m_mask;
        n_goal   = (wr && a == 4'h1) ? wd : m_goal;
        n_last   = fv ? fval : m_last;
        n_irq    = |(m_status & m_mask);
        @(posedge clk);
        m_status = n_status; m_mask = n_mask; m_goal = n_goal;
        m_last = n_last; m_irq = n_irq;
        prev_tag = tag;
    endtask

    task automatic rd(string tag, logic [3:0] a);
        cyc(tag, 1'b0, 32'h0, 1'b0, 1'b0, a, 32'h0);
    endtask

    task automatic wr(string tag, logic [3:0] a, logic [31:0] d);
        cyc(tag, 1'b0, 32'h0, 1'b0, 1'b1, a, d);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        fence_valid = 0; fence_value = 0; progress_pulse = 0;
        host_wr = 0; host_addr = 4'h0; host_wdata = 0;
        m_mask = 0; m_status = 0; m_goal = 0; m_last = 0; m_irq = 0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: every register reads zero after reset
        rd("R1", 4'h0); rd("R1", 4'h1); rd("R1", 4'h2); rd("R1", 4'h8);

        // R2: map, field widths, unmapped address
        wr("R2", 4'h0, 32'hFFFF_FFF8);
        rd("R2", 4'h0);
        wr("R2", 4'h1, 32'h1234_5678);
        rd("R2", 4'h1);
        wr("R2", 4'h5, 32'hDEAD_BEEF);
        rd("R2", 4'h5);
        rd("R2", 4'h8);

        // R3 / R4: non-matching fence, no mask
        cyc("R3", 1'b1, 32'hAAAA_0001, 1'b0, 1'b0, 4'h2, 32'h0);
        rd("R4", 4'h8);

        // R5: progress
        cyc("R5", 1'b0, 32'h0, 1'b1, 1'b0, 4'h8, 32'h0);
        rd("R5", 4'h8);

        // R7: goal match while goal mask bit clear
        cyc("R7", 1'b1, 32'h1234_5678, 1'b0, 1'b0, 4'h8, 32'h0);
        rd("R7", 4'h8);

        // R8: write 0 keeps, write 1 clears selected bits
        wr("R8", 4'h8, 32'h0);
        rd("R8", 4'h8);
        wr("R8", 4'h8, 32'h1);
        rd("R8", 4'h8);
        wr("R8", 4'h8, 32'h7);
        rd("R8", 4'h8);

        // R6: goal match with goal mask bit set
        wr("R6", 4'h0, 32'h4);
        cyc("R6", 1'b1, 32'h1234_5678, 1'b0, 1'b0, 4'h8, 32'h0);
        rd("R10", 4'h8); rd("R10", 4'h8);

        // R10: interrupt follows mask changes one cycle late
        wr("R10", 4'h0, 32'h0);
        rd("R10", 4'h8); rd("R10", 4'h8);
        wr("R10", 4'h0, 32'h1);
        rd("R10", 4'h8); rd("R10", 4'h8);
        wr("R10", 4'h8, 32'h7);
        rd("R10", 4'h8); rd("R10", 4'h8);

        // R9: set wins over a same-cycle clear
        cyc("R9", 1'b1, 32'h0000_0042, 1'b0, 1'b1, 4'h8, 32'h1);
        rd("R9", 4'h8);
        cyc("R9", 1'b0, 32'h0, 1'b1, 1'b1, 4'h8, 32'h2);
        rd("R9", 4'h8);

        // R6: same-cycle goal write, fence matches the old goal
        wr("R6", 4'h0, 32'h4);
        wr("R6", 4'h8, 32'h7);
        cyc("R6", 1'b1, 32'h1234_5678, 1'b0, 1'b1, 4'h1, 32'h0000_0099);
        rd("R6", 4'h8);
        wr("R6", 4'h8, 32'h7);
        cyc("R6", 1'b1, 32'h0000_0099, 1'b0, 1'b1, 4'h1, 32'h0000_0055);
        rd("R6", 4'h8);

        // R11: write to last-fence address ignored
        wr("R11", 4'h2, 32'h5555_AAAA);
        rd("R11", 4'h2);

        // mixed traffic against the reference model
        wr("R6", 4'h1, 32'h0000_0010);
        for (int i = 0; i < 400; i++) begin
            logic [31:0] v;
            logic [3:0]  a;
            int          sel;
            sel = $urandom_range(0, 3);
            v   = (sel == 0) ? 32'h10 : (sel == 1) ? 32'h11 : $urandom;
            case ($urandom_range(0, 4))
                0: a = 4'h0; 1: a = 4'h1; 2: a = 4'h2; 3: a = 4'h8; default: a = 4'h8;
            endcase
            cyc("R8", 1'($urandom_range(0, 1)), v, 1'($urandom_range(0, 3) == 0),
                1'($urandom_range(0, 3) == 0), a,
                (a == 4'h1) ? 32'h10 : 32'($urandom_range(0, 7)));
        end
        rd("R8", 4'h8);
        rd("R8", 4'h8);

        done = 1;
        summary();
        $finish;
    end

endmodule